// File: doc/BRIEF.md
# Interrupt Redirection and Routing Unit

This unit sits between a chip's interrupt input pins and the processor-side interrupt controllers. It holds a programmable table of 24 entries, one per pin. Each 64-bit entry says how its pin is qualified (active level, edge or level sensing, mask) and what request it produces (vector, delivery mode, physical or logical addressing, destination ID). Qualifying pin activity becomes a delivery request. The request is held on a valid/accept handshake until a receiver takes it.

Level-sensed entries carry a remote-acknowledge flag. The flag is set when such a request is accepted, and it blocks any further delivery from that pin. It is cleared when an end-of-interrupt message arrives whose vector equals the entry's vector. Each entry also reports a read-only pending flag, so software can see whether a request is waiting. Pins are asynchronous and pass through a parameterised synchronizer before they are qualified.

Top module: `irq_route_unit`

## Requirements
- R1: After reset every entry reads 64'h0000_0000_0001_0000 (only the mask bit 16 set) and req_valid is 0.
- R2: A write to an address below 24 stores vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger [15], mask [16], extended destination [55:48] and destination [63:56]. The pending flag [12] and the remote-acknowledge flag [14] ignore write data. All other bits read 0. Addresses 24 and above read 0 and ignore writes.
- R3: With polarity bit 13 at 1 a pin is active when high; with it at 0 a pin is active when low.
- R4: An edge entry (bit 15 = 1) raises exactly one request for each inactive-to-active transition. A pin held active raises no further request.
- R5: A level entry (bit 15 = 0) requests while its pin is active and its remote-acknowledge flag is 0. Accepting the request sets the flag to 1, and no request comes from that entry while the flag stays 1.
- R6: An end-of-interrupt clears the remote-acknowledge flag of every level entry whose vector equals eoi_vector. Entries with a different vector keep their flag.
- R7: While mask bit 16 is 1 the entry produces no request and its pending flag does not rise.
- R8: When several entries are pending, the lowest pin index is offered first. One request is retired per accepted handshake. req_vector, req_mode, req_dest_logical, req_dest and req_pin come from the offered entry.
- R9: The pending flag (bit 12) reads 1 while a request from the entry waits and reads 0 once that request has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pins | input | 24 | Raw interrupt inputs, one per table entry |
| cfg_addr | input | 5 | Entry index for register read and write |
| cfg_wr | input | 1 | Write strobe for the addressed entry |
| cfg_wdata | input | 64 | Entry write data |
| cfg_rdata | output | 64 | Addressed entry contents including status flags, combinational |
| req_valid | output | 1 | A delivery request is offered |
| req_accept | input | 1 | Receiver takes the offered request this cycle |
| req_vector | output | 8 | Vector of the offered request |
| req_mode | output | 3 | Delivery mode of the offered request |
| req_dest_logical | output | 1 | 1 for logical addressing, 0 for physical |
| req_dest | output | 8 | Destination ID of the offered request |
| req_pin | output | 5 | Pin index of the offered request |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |

## Verification
A table of edge entries covers both polarities, several delivery modes, both addressing modes and pins at the low and high ends of the table. This shows that every request field is routed from the correct entry. A pin held active after acceptance and then toggled separates true edge detection from level-style re-triggering. Two level entries share one vector, and end-of-interrupts with a matching and a non-matching vector show that the acknowledge flag blocks re-delivery and that a single end-of-interrupt releases every matching entry. Three edges that arrive in the same cycle, and a level pin raised while its entry is masked, check the fixed priority order and mask suppression.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ENTRY_W  = 64;
    localparam int VEC_W    = 8;
    localparam int DEST_W   = 8;
    localparam int MODE_W   = 3;

    // bit positions of the flags inside an entry word
    localparam int B_DLOG   = 11;
    localparam int B_STATUS = 12;
    localparam int B_POL    = 13;
    localparam int B_RIRR   = 14;
    localparam int B_TRIG   = 15;
    localparam int B_MASK   = 16;
    localparam int B_EXT    = 48;
    localparam int B_DEST   = 56;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV3   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_RSV6   = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [DEST_W-1:0] ext_dest;
        logic              mask;
        logic              trig_edge;
        logic              pol_high;
        logic              dest_logical;
        dmode_e            mode;
        logic [VEC_W-1:0]  vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{
        dest: '0, ext_dest: '0, mask: 1'b1, trig_edge: 1'b0,
        pol_high: 1'b0, dest_logical: 1'b0, mode: DM_FIXED, vector: '0
    };

    function automatic entry_t word_to_entry(input logic [ENTRY_W-1:0] w);
        entry_t e;
        e.vector       = w[VEC_W-1:0];
        e.mode         = dmode_e'(w[VEC_W+MODE_W-1:VEC_W]);
        e.dest_logical = w[B_DLOG];
        e.pol_high     = w[B_POL];
        e.trig_edge    = w[B_TRIG];
        e.mask         = w[B_MASK];
        e.ext_dest     = w[B_EXT+DEST_W-1:B_EXT];
        e.dest         = w[B_DEST+DEST_W-1:B_DEST];
        return e;
    endfunction

    function automatic logic [ENTRY_W-1:0] entry_to_word(input entry_t e,
                                                         input logic pending,
                                                         input logic remote_ack);
        logic [ENTRY_W-1:0] w;
        w = '0;
        w[VEC_W-1:0]                = e.vector;
        w[VEC_W+MODE_W-1:VEC_W]     = e.mode;
        w[B_DLOG]                   = e.dest_logical;
        w[B_STATUS]                 = pending;
        w[B_POL]                    = e.pol_high;
        w[B_RIRR]                   = remote_ack;
        w[B_TRIG]                   = e.trig_edge;
        w[B_MASK]                   = e.mask;
        w[B_EXT+DEST_W-1:B_EXT]     = e.ext_dest;
        w[B_DEST+DEST_W-1:B_DEST]   = e.dest;
        return w;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int WIDTH  = 24,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign synced = raw;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

            always_comb begin
                chain_d[0] = raw;
                for (int s = 1; s < STAGES; s++) begin
                    chain_d[s] = chain_q[s-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign synced = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N     = 24,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
        any = |cand;
    end
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS    = 24,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_pins,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic                cfg_wr,
    input  logic [ENTRY_W-1:0]  cfg_wdata,
    output logic [ENTRY_W-1:0]  cfg_rdata,
    output logic                req_valid,
    input  logic                req_accept,
    output logic [VEC_W-1:0]    req_vector,
    output logic [MODE_W-1:0]   req_mode,
    output logic                req_dest_logical,
    output logic [DEST_W-1:0]   req_dest,
    output logic [ADDR_W-1:0]   req_pin,
    input  logic                eoi_valid,
    input  logic [VEC_W-1:0]    eoi_vector
);

    typedef struct packed {
        entry_t [NUM_PINS-1:0] tbl;
        logic   [NUM_PINS-1:0] pend;
        logic   [NUM_PINS-1:0] rack;
        logic   [NUM_PINS-1:0] act;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] mask_vec;
    logic [NUM_PINS-1:0] edge_vec;
    logic [NUM_PINS-1:0] pend_vec;
    logic [NUM_PINS-1:0] rirr_vec;
    logic [NUM_PINS-1:0] eligible;
    logic [NUM_PINS-1:0] retire;
    logic [NUM_PINS-1:0] act_now;
    logic [NUM_PINS-1:0] rise;
    logic [ADDR_W-1:0]   pick_idx;
    logic                pick_any;
    logic                handshake;

    irq_pin_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_pins),
        .synced (pin_sync)
    );

    // per-entry flag views of the current state
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            mask_vec[i] = st_q.tbl[i].mask;
            edge_vec[i] = st_q.tbl[i].trig_edge;
            act_now[i]  = st_q.tbl[i].pol_high ? pin_sync[i] : ~pin_sync[i];
        end
        pend_vec = st_q.pend;
        rirr_vec = st_q.rack;
        eligible = st_q.pend & ~mask_vec;
        rise     = act_now & ~st_q.act;
    end

    irq_prio_pick #(
        .N     (NUM_PINS),
        .IDX_W (ADDR_W)
    ) u_pick (
        .cand (eligible),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    assign handshake = pick_any & req_accept;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            retire[i] = handshake && (pick_idx == ADDR_W'(i));
        end
    end

    // next-state computation
    always_comb begin
        st_d = st_q;

        for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg_wr && cfg_addr == ADDR_W'(i)) begin
                st_d.tbl[i] = word_to_entry(cfg_wdata);
            end
        end

        for (int i = 0; i < NUM_PINS; i++) begin
            if (st_d.tbl[i].trig_edge) begin
                st_d.rack[i] = 1'b0;
                st_d.pend[i] = (st_q.pend[i] & ~retire[i])
                             | (rise[i] & ~st_d.tbl[i].mask);
            end else begin
                if (eoi_valid && st_d.tbl[i].vector == eoi_vector) begin
                    st_d.rack[i] = 1'b0;
                end
                if (retire[i]) begin
                    st_d.rack[i] = 1'b1;
                end
                st_d.pend[i] = act_now[i] & ~st_d.tbl[i].mask & ~st_d.rack[i];
            end
        end

        st_d.act = act_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tbl  <= {NUM_PINS{ENTRY_RST}};
            st_q.pend <= '0;
            st_q.rack <= '0;
            st_q.act  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // register read and request field selection
    always_comb begin
        cfg_rdata        = '0;
        req_vector       = '0;
        req_mode         = '0;
        req_dest_logical = 1'b0;
        req_dest         = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg_addr == ADDR_W'(i)) begin
                cfg_rdata = entry_to_word(st_q.tbl[i], st_q.pend[i], st_q.rack[i]);
            end
            if (pick_idx == ADDR_W'(i)) begin
                req_vector       = st_q.tbl[i].vector;
                req_mode         = st_q.tbl[i].mode;
                req_dest_logical = st_q.tbl[i].dest_logical;
                req_dest         = st_q.tbl[i].dest;
            end
        end
    end

    assign req_valid = pick_any;
    assign req_pin   = pick_idx;

endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
    parameter int N      = 24,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_accept,
    input logic [ADDR_W-1:0] req_pin,
    input logic              cfg_wr,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      rirr,
    input logic [N-1:0]      mask_v,
    input logic [N-1:0]      edge_v
);
    logic [N-1:0] below;
    assign below = ({{(N-1){1'b0}}, 1'b1} << req_pin) - {{(N-1){1'b0}}, 1'b1};

    AST_OFFER_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (pend[req_pin] && !mask_v[req_pin]));                   // R9

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((pend & ~mask_v & below) == '0));                      // R8

    AST_IDLE_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask_v) == '0) |-> !req_valid);                             // R7

    AST_ACK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr & pend) == '0);                                                 // R5

    AST_ACK_LEVEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr & edge_v) == '0);                                               // R4

    AST_ACCEPT_SETS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_accept && !cfg_wr && !edge_v[req_pin])
        |=> rirr[$past(req_pin)]);                                            // R5
endmodule

bind irq_route_unit irq_route_checker #(
    .N      (NUM_PINS),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .req_pin    (req_pin),
    .cfg_wr     (cfg_wr),
    .pend       (pend_vec),
    .rirr       (rirr_vec),
    .mask_v     (mask_vec),
    .edge_v     (edge_vec)
);

// File: tb/irq_route_unit_test.sv
module irq_route_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_pins = '0;
    logic [4:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        req_valid;
    logic        req_accept = 1'b0;
    logic [7:0]  req_vector;
    logic [2:0]  req_mode;
    logic        req_dest_logical;
    logic [7:0]  req_dest;
    logic [4:0]  req_pin;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_route_unit uut (
        .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins),
        .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_accept(req_accept),
        .req_vector(req_vector), .req_mode(req_mode),
        .req_dest_logical(req_dest_logical), .req_dest(req_dest),
        .req_pin(req_pin), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
    );

    typedef struct packed {
        logic [7:0] pin;
        logic       pol;
        logic [7:0] vec;
        logic [2:0] mode;
        logic       dlog;
        logic [7:0] dest;
    } row_t;

    localparam row_t ROWS [0:5] = '{
        '{8'd0,  1'b1, 8'h31, 3'd0, 1'b0, 8'h01},
        '{8'd4,  1'b0, 8'h49, 3'd1, 1'b1, 8'h0F},
        '{8'd12, 1'b1, 8'h89, 3'd4, 1'b0, 8'hA0},
        '{8'd17, 1'b0, 8'hB1, 3'd5, 1'b1, 8'h03},
        '{8'd22, 1'b1, 8'hC1, 3'd7, 1'b0, 8'hFF},
        '{8'd23, 1'b0, 8'h20, 3'd2, 1'b1, 8'h80}
    };

    function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                       input logic dlog, input logic pol, input logic trig,
                                       input logic msk, input logic [7:0] dest);
        logic [63:0] w;
        w = '0;
        w[7:0]   = vec;
        w[10:8]  = mode;
        w[11]    = dlog;
        w[13]    = pol;
        w[15]    = trig;
        w[16]    = msk;
        w[63:56] = dest;
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [63:0] d);
        @(negedge clk);
        cfg_addr = a[4:0]; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [63:0] d);
        @(negedge clk);
        cfg_addr = a[4:0];
        #1 d = cfg_rdata;
    endtask

    task automatic take();
        @(negedge clk);
        req_accept = 1'b1;
        @(negedge clk);
        req_accept = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        int p;
        cyc(3);
        rst_n = 1'b1;
        cyc(4);

        // R1 reset contents
        rd(0, d);  chk("R1 entry0", d, 64'h0000_0000_0001_0000);
        rd(23, d); chk("R1 entry23", d, 64'h0000_0000_0001_0000);
        chk("R1 idle", {63'b0, req_valid}, 64'd0);

        // R2 write layout, read-only flags, out of range
        wr(5, '1);
        rd(5, d);  chk("R2 stored fields", d, 64'hFFFF_0000_0001_AFFF);
        wr(24, 64'h1234);
        rd(24, d); chk("R2 out of range", d, 64'd0);
        wr(5, 64'h0000_0000_0001_0000);

        // R3 R8 R9 table walk over edge entries
        foreach (ROWS[k]) begin
            p = int'(ROWS[k].pin);
            irq_pins[p] = ~ROWS[k].pol;
            wr(p, mk(ROWS[k].vec, ROWS[k].mode, ROWS[k].dlog, ROWS[k].pol, 1'b1, 1'b0, ROWS[k].dest));
            cyc(4);
            chk("R3 inactive level", {63'b0, req_valid}, 64'd0);
            irq_pins[p] = ROWS[k].pol;
            cyc(5);
            chk("R8 valid", {63'b0, req_valid}, 64'd1);
            chk("R8 pin", {59'b0, req_pin}, 64'(p));
            chk("R8 vector", {56'b0, req_vector}, {56'b0, ROWS[k].vec});
            chk("R8 mode", {61'b0, req_mode}, {61'b0, ROWS[k].mode});
            chk("R8 dest mode", {63'b0, req_dest_logical}, {63'b0, ROWS[k].dlog});
            chk("R8 dest", {56'b0, req_dest}, {56'b0, ROWS[k].dest});
            rd(p, d); chk("R9 pending set", {63'b0, d[12]}, 64'd1);
            take();
            cyc(3);
            chk("R9 retired", {63'b0, req_valid}, 64'd0);
            rd(p, d); chk("R9 pending clear", {63'b0, d[12]}, 64'd0);
            wr(p, mk(ROWS[k].vec, ROWS[k].mode, ROWS[k].dlog, ROWS[k].pol, 1'b1, 1'b1, ROWS[k].dest));
            irq_pins[p] = 1'b0;
        end

        // R4 held pin gives one request, new edge gives another
        wr(6, mk(8'h59, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h02));
        irq_pins[6] = 1'b1;
        cyc(5);
        chk("R4 first edge", {59'b0, req_pin, 1'b0, req_valid}, {59'd6, 2'b01});
        take();
        cyc(10);
        chk("R4 held no retrigger", {63'b0, req_valid}, 64'd0);
        irq_pins[6] = 1'b0; cyc(4);
        irq_pins[6] = 1'b1; cyc(5);
        chk("R4 second edge", {63'b0, req_valid}, 64'd1);
        take();
        wr(6, 64'h0000_0000_0001_0000);
        irq_pins[6] = 1'b0;

        // R5 R6 level entries sharing a vector, pin 7 active-low (R3)
        irq_pins[3] = 1'b0; irq_pins[7] = 1'b1;
        wr(3, mk(8'h44, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h02));
        wr(7, mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h05));
        cyc(4);
        chk("R5 level idle", {63'b0, req_valid}, 64'd0);
        irq_pins[3] = 1'b1; cyc(5);
        chk("R5 level req", {56'b0, req_vector, 2'b0, req_pin, req_valid}, {48'b0, 8'h44, 2'b0, 5'd3, 1'b1});
        take();
        rd(3, d); chk("R5 ack set", {62'b0, d[14], d[12]}, 64'b10);
        cyc(6);
        chk("R5 blocked", {63'b0, req_valid}, 64'd0);
        eoi(8'h45); cyc(3);
        rd(3, d); chk("R6 other vector keeps ack", {63'b0, d[14]}, 64'd1);
        chk("R6 still blocked", {63'b0, req_valid}, 64'd0);
        irq_pins[7] = 1'b0; cyc(5);
        chk("R3 active-low level", {58'b0, req_pin, req_valid}, {58'b0, 5'd7, 1'b1});
        take();
        eoi(8'h44); cyc(3);
        chk("R6 both released lowest first", {58'b0, req_pin, req_valid}, {58'b0, 5'd3, 1'b1});
        rd(7, d); chk("R6 entry7 ack clear", {62'b0, d[14], d[12]}, 64'b01);
        take();
        chk("R8 next offer", {58'b0, req_pin, req_valid}, {58'b0, 5'd7, 1'b1});
        take();
        irq_pins[3] = 1'b0; irq_pins[7] = 1'b1;
        eoi(8'h44); cyc(4);
        chk("R5 inactive after release", {63'b0, req_valid}, 64'd0);
        wr(3, 64'h0000_0000_0001_0000);
        wr(7, 64'h0000_0000_0001_0000);
        irq_pins[7] = 1'b0;

        // R8 simultaneous edges
        wr(2,  mk(8'h61, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01));
        wr(10, mk(8'h62, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01));
        wr(20, mk(8'h63, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01));
        cyc(3);
        irq_pins[2] = 1'b1; irq_pins[10] = 1'b1; irq_pins[20] = 1'b1;
        cyc(5);
        chk("R8 first of three", {56'b0, req_vector}, 64'h61);
        take();
        chk("R8 second of three", {56'b0, req_vector}, 64'h62);
        take();
        chk("R8 third of three", {56'b0, req_vector}, 64'h63);
        take();
        chk("R8 drained", {63'b0, req_valid}, 64'd0);
        wr(2, 64'h0000_0000_0001_0000);
        wr(10, 64'h0000_0000_0001_0000);
        wr(20, 64'h0000_0000_0001_0000);
        irq_pins[2] = 1'b0; irq_pins[10] = 1'b0; irq_pins[20] = 1'b0;

        // R7 masked level pin
        wr(9, mk(8'h71, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h01));
        irq_pins[9] = 1'b1;
        cyc(6);
        chk("R7 masked no req", {63'b0, req_valid}, 64'd0);
        rd(9, d); chk("R7 masked not pending", {63'b0, d[12]}, 64'd0);
        wr(9, mk(8'h71, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h01));
        cyc(3);
        chk("R7 unmasked req", {58'b0, req_pin, req_valid}, {58'b0, 5'd9, 1'b1});
        take();
        irq_pins[9] = 1'b0;
        eoi(8'h71);
        wr(9, 64'h0000_0000_0001_0000);

        finish_run();
    end

endmodule